// File: doc/BRIEF.md
# Voice PCM Serial Port

This block is the digital serial data port of a voice-band codec. In each frame it shifts one transmit sample out on a serial data line and gathers one receive sample in from another. The transmit sample arrives in parallel from surrounding logic. The received word is returned in parallel, together with a 3-bit volume code, on a one-cycle strobe. Companding arithmetic and the analog path are handled elsewhere.

Two timing schemes are supported, chosen by a strap. In fixed-rate mode the master clock is also the bit clock. A time-slot strobe marks the transmit slot so that an external three-state buffer can be enabled. In variable-rate mode separate transmit and receive data clocks pace the bits. These data clocks are synchronous to the master clock and are sampled as edge enables. In this mode the transmit word is sent again in every following slot for as long as the frame sync stays high, and the received word is taken from the last bits that arrive before the frame sync falls. A word-format pin selects 8-bit companded words or 16-bit linear words. A linear word carries a 13-bit two's-complement sample, followed on receive by a 3-bit volume code and on transmit by three zero bits.

Top module: `pcm_serial_port`

## Requirements
- R1: After reset, `sdo_oe` is low, `slot_n` is high and `rx_valid` is low.
- R2: In fixed-rate mode (`rate_fixed`=1), a rising edge of `tx_fs` that is sampled at a clock edge starts a slot. The word then appears on `sdo` MSB first, one bit per cycle, beginning in the cycle after that edge, with `sdo_oe` high for each bit. In companded mode (`comp_sel`=1) the word is `tx_sample[7:0]`, which gives 8 bits.
- R3: In linear mode (`comp_sel`=0) the transmitted word has 16 bits: `tx_sample[12:0]` MSB first, followed by three 0 bits.
- R4: In fixed-rate mode `slot_n` is low in exactly the cycles in which a word bit is driven. `slot_n` and `sdo_oe` both release in the cycle after the last bit.
- R5: In variable-rate mode (`rate_fixed`=0), bit 1 is on `sdo` with `sdo_oe` high in the cycle after the `tx_fs` rise is sampled. The first rising edge of `tx_dclk` keeps bit 1. Each later rising edge advances one bit.
- R6: In variable-rate mode the word starts again from bit 1 after its last bit, for as long as `tx_fs` stays high.
- R7: In variable-rate mode `sdo_oe` goes low in the cycle after the fall of `tx_fs` is sampled, and `slot_n` stays high throughout.
- R8: In fixed-rate mode the received word is made of the N bits sampled on the N clock edges that follow the sampled `rx_fs` rise (N=8 companded, 16 linear). Any bits on `sdi` after those are ignored.
- R9: In variable-rate mode each bit is taken on a falling edge of `rx_dclk` that follows a rising edge within the frame. The word is the last N bits taken before `rx_fs` falls.
- R10: A linear word is presented with its first 13 bits on `rx_sample` and its last 3 bits on `rx_vol`; 000 means no attenuation and each step adds 3 dB. A companded word is presented zero-extended on `rx_sample`, with `rx_vol`=000.
- R11: The volume code comes from each received word alone and is not carried over from an earlier frame.
- R12: `rx_valid` is high for exactly one cycle per received word. In fixed-rate mode this is the cycle after the last bit is sampled. In variable-rate mode it is the cycle after the `rx_fs` fall is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_fixed | input | 1 | Strap: 1 fixed-rate, 0 variable-rate |
| comp_sel | input | 1 | Word format: 1 companded (8 bits), 0 linear (16 bits) |
| tx_fs | input | 1 | Transmit frame sync |
| tx_dclk | input | 1 | Transmit data clock (variable-rate mode) |
| tx_sample | input | 13 | Parallel transmit sample |
| sdo | output | 1 | Serial transmit data |
| sdo_oe | output | 1 | Three-state enable for sdo |
| slot_n | output | 1 | Active-low transmit time-slot strobe (fixed-rate mode) |
| rx_fs | input | 1 | Receive frame sync |
| rx_dclk | input | 1 | Receive data clock (variable-rate mode) |
| sdi | input | 1 | Serial receive data |
| rx_sample | output | 13 | Received sample |
| rx_vol | output | 3 | Received volume code |
| rx_valid | output | 1 | One-cycle strobe for a received word |

## Verification
The bench builds the port with its default widths: a 13-bit linear sample, a 3-bit volume field and 8-bit companded words. This makes both the 8-bit and the 16-bit word lengths reachable in each timing mode. Variable-rate transmit slots are run for more data-clock edges than the word has bits, so the word repeats. Variable-rate receive frames carry more bits than the word needs, so the last-N selection can be seen, while fixed-rate frames carry trailing bits that must be ignored.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

  // Edge events of a signal sampled in the master-clock domain
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;

  typedef enum logic {
    RATE_VARIABLE = 1'b0,
    RATE_FIXED    = 1'b1
  } rate_e;

endpackage

// File: rtl/pcm_edge_det.sv
module pcm_edge_det
  import pcm_port_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sig,
  output edge_t ev
);

  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig;
  end

  assign ev.rise = sig & ~sig_q;
  assign ev.fall = ~sig & sig_q;

endmodule

// File: rtl/pcm_tx_serializer.sv
module pcm_tx_serializer
  import pcm_port_pkg::*;
#(
  parameter int LIN_W  = 13,
  parameter int VOL_W  = 3,
  parameter int COMP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fixed,
  input  logic             lin,
  input  edge_t            fs_ev,
  input  edge_t            dclk_ev,
  input  logic [LIN_W-1:0] sample,
  output logic             sdo,
  output logic             oe,
  output logic             slot_n
);

  localparam int FRAME_W = LIN_W + VOL_W;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_LIN  = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] LAST_COMP = CNT_W'(COMP_W - 1);

  logic               act_q,  act_d;
  logic               first_q, first_d;
  logic [CNT_W-1:0]   cnt_q,  cnt_d;
  logic [CNT_W-1:0]   last_q, last_d;
  logic [FRAME_W-1:0] sh_q,   sh_d;
  logic [FRAME_W-1:0] hold_q, hold_d;
  logic [FRAME_W-1:0] load_w;

  // Word image, MSB aligned; linear words carry zero padding
  always_comb begin
    if (lin) load_w = {sample, {VOL_W{1'b0}}};
    else     load_w = {sample[COMP_W-1:0], {(FRAME_W-COMP_W){1'b0}}};
  end

  always_comb begin
    act_d   = act_q;
    first_d = first_q;
    cnt_d   = cnt_q;
    last_d  = last_q;
    sh_d    = sh_q;
    hold_d  = hold_q;
    if (fs_ev.rise) begin
      act_d   = 1'b1;
      first_d = 1'b1;
      cnt_d   = '0;
      last_d  = lin ? LAST_LIN : LAST_COMP;
      sh_d    = load_w;
      hold_d  = load_w;
    end else if (fixed) begin
      if (act_q) begin
        if (cnt_q == last_q) begin
          act_d = 1'b0;
        end else begin
          sh_d  = sh_q << 1;
          cnt_d = cnt_q + 1'b1;
        end
      end
    end else if (fs_ev.fall) begin
      act_d = 1'b0;
    end else if (act_q) begin
      if (dclk_ev.fall) first_d = 1'b0;
      if (dclk_ev.rise && !first_q) begin
        if (cnt_q == last_q) begin
          sh_d  = hold_q;
          cnt_d = '0;
        end else begin
          sh_d  = sh_q << 1;
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      first_q <= 1'b0;
      cnt_q   <= '0;
      last_q  <= '0;
      sh_q    <= '0;
      hold_q  <= '0;
    end else begin
      act_q   <= act_d;
      first_q <= first_d;
      cnt_q   <= cnt_d;
      last_q  <= last_d;
      sh_q    <= sh_d;
      hold_q  <= hold_d;
    end
  end

  assign sdo    = act_q & sh_q[FRAME_W-1];
  assign oe     = act_q;
  assign slot_n = ~(act_q & fixed);

  // R2: a sampled frame-sync rise in fixed mode opens the slot next cycle
  a_r2_fixed_start: assert property (@(posedge clk) disable iff (!rst_n)
    (fixed && fs_ev.rise) |=> oe);

  // R4: the strobe releases right after the last bit
  a_r4_slot_release: assert property (@(posedge clk) disable iff (!rst_n)
    (fixed && !slot_n && cnt_q == last_q && !fs_ev.rise) |=> slot_n);

  // R7: variable mode output released after frame sync falls
  a_r7_var_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!fixed && fs_ev.fall) |=> !oe);

  // R3: padding bits of a linear word are zero
  a_r3_zero_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && last_q == LAST_LIN && cnt_q >= CNT_W'(LIN_W)) |-> !sdo);

endmodule

// File: rtl/pcm_rx_deserializer.sv
module pcm_rx_deserializer
  import pcm_port_pkg::*;
#(
  parameter int LIN_W  = 13,
  parameter int VOL_W  = 3,
  parameter int COMP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fixed,
  input  logic             lin,
  input  logic             sdi,
  input  edge_t            fs_ev,
  input  edge_t            dclk_ev,
  output logic [LIN_W-1:0] rx_sample,
  output logic [VOL_W-1:0] rx_vol,
  output logic             rx_valid
);

  localparam int FRAME_W = LIN_W + VOL_W;
  localparam int RCNT_W  = $clog2(FRAME_W + 1);
  localparam logic [RCNT_W-1:0] NEED_LIN  = RCNT_W'(FRAME_W);
  localparam logic [RCNT_W-1:0] NEED_COMP = RCNT_W'(COMP_W);

  logic               busy_q, busy_d;
  logic               open_q, open_d;
  logic               armed_q, armed_d;
  logic [RCNT_W-1:0]  cnt_q, cnt_d;
  logic [RCNT_W-1:0]  need_q, need_d;
  logic               lin_q, lin_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [FRAME_W-1:0] word_q, word_d;
  logic               wlin_q, wlin_d;
  logic               valid_q, emit;
  logic [FRAME_W-1:0] shifted;

  assign shifted = {sh_q[FRAME_W-2:0], sdi};

  always_comb begin
    busy_d  = busy_q;
    open_d  = open_q;
    armed_d = armed_q;
    cnt_d   = cnt_q;
    need_d  = need_q;
    lin_d   = lin_q;
    sh_d    = sh_q;
    word_d  = word_q;
    wlin_d  = wlin_q;
    emit    = 1'b0;
    if (fs_ev.rise) begin
      busy_d  = fixed;
      open_d  = ~fixed;
      armed_d = 1'b0;
      cnt_d   = '0;
      need_d  = lin ? NEED_LIN : NEED_COMP;
      lin_d   = lin;
    end else if (fixed) begin
      if (busy_q) begin
        sh_d = shifted;
        if (cnt_q == need_q - 1'b1) begin
          busy_d = 1'b0;
          emit   = 1'b1;
          word_d = shifted;
          wlin_d = lin_q;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end else if (fs_ev.fall) begin
      open_d = 1'b0;
      if (open_q && cnt_q >= need_q) begin
        emit   = 1'b1;
        word_d = sh_q;
        wlin_d = lin_q;
      end
    end else if (open_q) begin
      if (dclk_ev.rise) begin
        armed_d = 1'b1;
      end else if (dclk_ev.fall && armed_q) begin
        armed_d = 1'b0;
        sh_d    = shifted;
        if (cnt_q != need_q) cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      open_q  <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      need_q  <= '0;
      lin_q   <= 1'b0;
      sh_q    <= '0;
      word_q  <= '0;
      wlin_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      open_q  <= open_d;
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
      need_q  <= need_d;
      lin_q   <= lin_d;
      sh_q    <= sh_d;
      word_q  <= word_d;
      wlin_q  <= wlin_d;
      valid_q <= emit;
    end
  end

  // Field split of the captured word
  always_comb begin
    if (wlin_q) begin
      rx_sample = word_q[FRAME_W-1:VOL_W];
      rx_vol    = word_q[VOL_W-1:0];
    end else begin
      rx_sample = LIN_W'(word_q[COMP_W-1:0]);
      rx_vol    = '0;
    end
  end

  assign rx_valid = valid_q;

  // R12: one strobe per word
  a_r12_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R9: a variable-rate word is only reported on a frame-sync fall
  a_r9_var_emit: assert property (@(posedge clk) disable iff (!rst_n)
    (!fixed && !fs_ev.fall) |=> !rx_valid);

endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
  import pcm_port_pkg::*;
#(
  parameter int LIN_W  = 13,
  parameter int VOL_W  = 3,
  parameter int COMP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rate_fixed,
  input  logic             comp_sel,
  input  logic             tx_fs,
  input  logic             tx_dclk,
  input  logic [LIN_W-1:0] tx_sample,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             slot_n,
  input  logic             rx_fs,
  input  logic             rx_dclk,
  input  logic             sdi,
  output logic [LIN_W-1:0] rx_sample,
  output logic [VOL_W-1:0] rx_vol,
  output logic             rx_valid
);

  localparam int N_EDGE = 4;
  localparam int I_TXFS = 0;
  localparam int I_TXDC = 1;
  localparam int I_RXFS = 2;
  localparam int I_RXDC = 3;

  logic [1:0]        rst_sync_q;
  logic              rst_n_i;
  logic [N_EDGE-1:0] edge_in;
  edge_t             ev [N_EDGE];
  rate_e             mode;
  logic              lin;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  assign mode = rate_e'(rate_fixed);
  assign lin  = ~comp_sel;

  assign edge_in[I_TXFS] = tx_fs;
  assign edge_in[I_TXDC] = tx_dclk;
  assign edge_in[I_RXFS] = rx_fs;
  assign edge_in[I_RXDC] = rx_dclk;

  for (genvar g = 0; g < N_EDGE; g++) begin : g_edge
    pcm_edge_det u_edge (
      .clk   (clk),
      .rst_n (rst_n_i),
      .sig   (edge_in[g]),
      .ev    (ev[g])
    );
  end

  pcm_tx_serializer #(
    .LIN_W  (LIN_W),
    .VOL_W  (VOL_W),
    .COMP_W (COMP_W)
  ) u_tx (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .fixed   (mode == RATE_FIXED),
    .lin     (lin),
    .fs_ev   (ev[I_TXFS]),
    .dclk_ev (ev[I_TXDC]),
    .sample  (tx_sample),
    .sdo     (sdo),
    .oe      (sdo_oe),
    .slot_n  (slot_n)
  );

  pcm_rx_deserializer #(
    .LIN_W  (LIN_W),
    .VOL_W  (VOL_W),
    .COMP_W (COMP_W)
  ) u_rx (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .fixed     (mode == RATE_FIXED),
    .lin       (lin),
    .sdi       (sdi),
    .fs_ev     (ev[I_RXFS]),
    .dclk_ev   (ev[I_RXDC]),
    .rx_sample (rx_sample),
    .rx_vol    (rx_vol),
    .rx_valid  (rx_valid)
  );

  // R7: the strobe is never driven in variable-rate mode
  a_r7_slot_var_idle: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!rate_fixed && $stable(rate_fixed)) |=> (slot_n || rate_fixed));

endmodule

// File: tb/pcm_serial_port_test.sv
module pcm_serial_port_test;

  logic        clk;
  logic        rst_n;
  logic        rate_fixed;
  logic        comp_sel;
  logic        tx_fs;
  logic        tx_dclk;
  logic [12:0] tx_sample;
  logic        sdo;
  logic        sdo_oe;
  logic        slot_n;
  logic        rx_fs;
  logic        rx_dclk;
  logic        sdi;
  logic [12:0] rx_sample;
  logic [2:0]  rx_vol;
  logic        rx_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  bit live   = 0;

  typedef struct {
    logic [12:0] s;
    logic [2:0]  v;
    string       req;
  } exp_t;
  exp_t sb[$];

  pcm_serial_port uut (
    .clk(clk), .rst_n(rst_n), .rate_fixed(rate_fixed), .comp_sel(comp_sel),
    .tx_fs(tx_fs), .tx_dclk(tx_dclk), .tx_sample(tx_sample),
    .sdo(sdo), .sdo_oe(sdo_oe), .slot_n(slot_n),
    .rx_fs(rx_fs), .rx_dclk(rx_dclk), .sdi(sdi),
    .rx_sample(rx_sample), .rx_vol(rx_vol), .rx_valid(rx_valid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: every strobe must match the next expected word
  always @(negedge clk) begin
    if (live && rx_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R12 unexpected word", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(rx_sample === e.s && rx_vol === e.v, e.req,
              {rx_sample, rx_vol}, {e.s, e.v});
      end
    end
  end

  task automatic push_exp(input logic [15:0] w, input bit lin, input string req);
    exp_t e;
    e.req = req;
    if (lin) begin e.s = w[15:3];          e.v = w[2:0]; end
    else     begin e.s = {5'b0, w[7:0]};   e.v = 3'b000; end
    sb.push_back(e);
  endtask

  task automatic tx_fixed(input logic [12:0] s, input bit lin, input string req);
    logic [15:0] w;
    int n;
    w = lin ? {s, 3'b000} : {s[7:0], 8'h00};
    n = lin ? 16 : 8;
    @(posedge clk); #2;
    comp_sel = ~lin; tx_sample = s; tx_fs = 1'b1;
    @(posedge clk); #2;
    tx_fs = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(sdo === w[15-i] && sdo_oe === 1'b1, req, {sdo_oe, sdo}, {1'b1, w[15-i]});
      check(slot_n === 1'b0, "R4 strobe low in slot", slot_n, 0);
      @(posedge clk);
    end
    @(negedge clk);
    check(sdo_oe === 1'b0 && slot_n === 1'b1, "R4 release after last bit",
          {sdo_oe, slot_n}, 2'b01);
  endtask

  task automatic tx_var(input logic [12:0] s, input bit lin, input int nrise);
    logic [15:0] w;
    int n;
    int b;
    w = lin ? {s, 3'b000} : {s[7:0], 8'h00};
    n = lin ? 16 : 8;
    @(posedge clk); #2;
    comp_sel = ~lin; tx_sample = s; tx_fs = 1'b1;
    @(posedge clk); #2;
    @(negedge clk);
    check(sdo === w[15] && sdo_oe === 1'b1, "R5 bit1 after frame sync",
          {sdo_oe, sdo}, {1'b1, w[15]});
    for (int r = 1; r <= nrise; r++) begin
      @(posedge clk); #2;
      tx_dclk = 1'b1;
      @(posedge clk); #2;
      tx_dclk = 1'b0;
      @(negedge clk);
      b = (r - 1) % n;
      check(sdo === w[15-b] && sdo_oe === 1'b1, (r > n) ? "R6 repeat" : "R5 advance",
            {sdo_oe, sdo}, {1'b1, w[15-b]});
      check(slot_n === 1'b1, "R7 strobe idle", slot_n, 1);
    end
    @(posedge clk); #2;
    tx_fs = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(sdo_oe === 1'b0, "R7 release on frame sync fall", sdo_oe, 0);
  endtask

  task automatic rx_fixed(input logic [15:0] w, input bit lin, input string req);
    logic [15:0] x;
    int n;
    n = lin ? 16 : 8;
    x = lin ? w : {w[7:0], 8'h00};
    push_exp(w, lin, req);
    @(posedge clk); #2;
    comp_sel = ~lin; rx_fs = 1'b1;
    @(posedge clk); #2;
    rx_fs = 1'b0; sdi = x[15];
    for (int i = 1; i < n; i++) begin
      @(posedge clk); #2;
      sdi = x[15-i];
    end
    @(posedge clk); #2;
    sdi = ~sdi;
    @(negedge clk);
    check(rx_valid === 1'b1, "R12 strobe after last bit", rx_valid, 1);
    @(posedge clk); #2;
    sdi = ~sdi;
    @(negedge clk);
    check(rx_valid === 1'b0, "R12 single cycle", rx_valid, 0);
    // trailing bits keep toggling; R8 says they are ignored
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #2;
      sdi = ~sdi;
    end
    @(negedge clk);
    check(rx_valid === 1'b0, "R8 trailing bits ignored", rx_valid, 0);
    sdi = 1'b0;
  endtask

  task automatic rx_var(input logic [31:0] stream, input int nbits, input bit lin,
                        input string req);
    push_exp(stream[15:0], lin, req);
    @(posedge clk); #2;
    comp_sel = ~lin; rx_fs = 1'b1;
    @(posedge clk); #2;
    for (int i = nbits - 1; i >= 0; i--) begin
      rx_dclk = 1'b1; sdi = stream[i];
      @(posedge clk); #2;
      rx_dclk = 1'b0;
      @(posedge clk); #2;
    end
    @(negedge clk);
    check(rx_valid === 1'b0, "R12 no strobe while frame open", rx_valid, 0);
    @(posedge clk); #2;
    rx_fs = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(rx_valid === 1'b1, "R12 strobe after frame sync fall", rx_valid, 1);
    @(negedge clk);
    check(rx_valid === 1'b0, "R12 single cycle", rx_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rate_fixed = 1'b1; comp_sel = 1'b1;
    tx_fs = 1'b0; tx_dclk = 1'b0; tx_sample = '0;
    rx_fs = 1'b0; rx_dclk = 1'b1; sdi = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(sdo_oe === 1'b0, "R1 oe idle", sdo_oe, 0);
    check(slot_n === 1'b1, "R1 strobe idle", slot_n, 1);
    check(rx_valid === 1'b0, "R1 no strobe", rx_valid, 0);
    live = 1;

    // Fixed-rate mode
    tx_fixed(13'h00A5, 1'b0, "R2 companded word");
    tx_fixed(13'h1A5B, 1'b1, "R3 linear word");
    tx_fixed(13'h1FFF, 1'b1, "R3 zero padding");
    rx_fixed(16'h00C3, 1'b0, "R8 companded first bits");
    rx_fixed(16'hB2E5, 1'b1, "R10 linear fields");
    rx_fixed(16'h7FF8, 1'b1, "R11 volume not held");

    // Variable-rate mode
    @(posedge clk); #2;
    rate_fixed = 1'b0; rx_dclk = 1'b0;
    repeat (3) @(posedge clk);
    tx_var(13'h005A, 1'b0, 11);
    tx_var(13'h0F0F, 1'b1, 18);
    rx_var(32'h0000_0A3C, 12, 1'b0, "R9 last eight bits");
    rx_var(32'h0001_2347, 20, 1'b1, "R10 variable linear fields");
    rx_var(32'h0000_5550, 16, 1'b1, "R11 volume zero after seven");

    repeat (6) @(posedge clk);
    @(negedge clk);
    check(sb.size() == 0, "R12 every word reported", sb.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule